// File: doc/BRIEF.md
# Link Speed and Duplex Resolver

This block settles the operating mode of a 10/100 copper port. Software writes a 16-bit control word that holds an auto-negotiation enable, a forced speed, a forced duplex and a self-clearing restart. The receive side reports three things: when a link is present, the ability word the partner advertised, and a parallel-detect result. The parallel-detect result is used when the partner does not negotiate. The resolver either adopts the forced settings or picks the best mode that both ends support. It then raises `link_up` with the chosen speed and duplex, and it pulses `status_upd` whenever a resolution finishes.

The chosen mode is held in registers that load only when a resolution completes. A change of duplex, of the negotiation enable or of the local abilities made while the link is up therefore waits for a restart or for the link to drop and return. A forced speed that differs from the running speed is the one exception: it makes the block request a link drop and resolve again. When the two ends share no mode, the port stays down and flags the failure. The failure clears on a restart or when the link goes away.

Top module: `port_mode_resolver`

## Requirements
- R1: After a synchronous reset, `link_up`, `res_fail`, `status_upd`, `link_down_req` and `lp_abil_q` are all zero. `ctl_rdata` reads 16'h3100, meaning negotiation enabled (bit 12), forced speed 100 (bit 13 = 1), forced duplex full (bit 8 = 1) and restart clear (bit 9 = 0).
- R2: Ability vectors use bit 3 for 100 full, bit 2 for 100 half, bit 1 for 10 full and bit 0 for 10 half. During negotiation, a valid partner word selects the highest bit set in both the local and the partner vectors. `link_up`, `mode_speed100` and `mode_full` show that choice after the clock edge that samples the partner word.
- R3: If the local and partner vectors have no bit in common, the port stays down and `res_fail` goes high. `res_fail` holds until a restart or until `rx_link_ok` drops.
- R4: When negotiation is pending, a `pd_valid` with no partner word resolves to half duplex at the speed given by `pd_speed100`. This succeeds only if the matching local half-duplex bit is set; otherwise the port fails. `lp_abil_q` reads zero after a parallel-detect resolution.
- R5: With bit 12 clear, a present link comes up one edge after the port reaches the down state. It uses bit 13 as the speed and bit 8 as the duplex, and no partner word is needed.
- R6: Writing bit 9 as one makes `ctl_rdata[9]` read one for exactly one cycle. The port then returns to the down state and resolves again. `link_down_req` pulses if the link was up.
- R7: While the link is up, a write with bit 12 clear and a bit 13 that differs from `mode_speed100` pulses `link_down_req` two edges after the write. The port then resolves again with the new settings.
- R8: While the link is up, writes that leave the running speed alone and changes of `local_abil` do not alter `link_up`, `mode_speed100` or `mode_full`.
- R9: `status_upd` is a one-cycle pulse on every completed resolution, whether it succeeds or fails. A negotiated resolution also loads `lp_abil_q` with the partner word.
- R10: When `rx_link_ok` is low, `link_up` is low after the next edge. Partner words are ignored in that state, and resolution restarts once the link returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word write data |
| ctl_rdata | output | 16 | Control word readback, bit 9 shows a pending restart |
| local_abil | input | 4 | Local ability vector |
| lp_abil_valid | input | 1 | Partner ability word valid |
| lp_abil | input | 4 | Partner ability vector |
| pd_valid | input | 1 | Parallel-detect result valid |
| pd_speed100 | input | 1 | Parallel-detected speed is 100 |
| rx_link_ok | input | 1 | Receive side sees a usable link |
| link_up | output | 1 | Port is up in the resolved mode |
| res_fail | output | 1 | Resolution found no common mode |
| mode_speed100 | output | 1 | Resolved speed is 100 |
| mode_full | output | 1 | Resolved duplex is full |
| link_down_req | output | 1 | One-cycle request to drop the link |
| status_upd | output | 1 | One-cycle pulse on each completed resolution |
| lp_abil_q | output | 4 | Partner ability captured at resolution |

## Verification
A corrupted state register appears at `link_up` or `res_fail` on the edge after a partner word or a link change. A missed restart appears as `ctl_rdata[9]` staying high past its single cycle, or as a missing `link_down_req` two edges after the write. A wrongly latched mode appears at `mode_speed100` and `mode_full` the cycle the port comes up. A failed deferral appears as those bits changing while `link_up` stays high, so each check samples on the edge that follows the stimulus.

// File: rtl/lmr_pkg.sv
package lmr_pkg;
  localparam int CTL_W  = 16;
  localparam int B_AN   = 12;
  localparam int B_SPD  = 13;
  localparam int B_DUP  = 8;
  localparam int B_RST  = 9;
  localparam int ABIL_W = 4;

  typedef enum logic [1:0] {
    ST_DOWN = 2'd0,
    ST_NEGO = 2'd1,
    ST_UP   = 2'd2,
    ST_FAIL = 2'd3
  } lmr_state_e;
endpackage

// File: rtl/lmr_ctl_regs.sv
module lmr_ctl_regs
  import lmr_pkg::*;
#(
  parameter int W = CTL_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         link_up,
  input  logic         cur_spd,
  output logic         an_en,
  output logic         spd,
  output logic         dup,
  output logic         reneg,
  output logic [W-1:0] rdata
);
  logic spd_chg;

  // a forced speed that differs from the running one cannot be deferred
  always_comb spd_chg = wr && link_up && !wdata[B_AN] && (wdata[B_SPD] != cur_spd);

  always_ff @(posedge clk) begin
    if (rst) begin
      an_en <= 1'b1;
      spd   <= 1'b1;
      dup   <= 1'b1;
      reneg <= 1'b0;
    end else begin
      reneg <= wr && (wdata[B_RST] || spd_chg);
      if (wr) begin
        an_en <= wdata[B_AN];
        spd   <= wdata[B_SPD];
        dup   <= wdata[B_DUP];
      end
    end
  end

  always_comb begin
    rdata        = '0;
    rdata[B_AN]  = an_en;
    rdata[B_SPD] = spd;
    rdata[B_DUP] = dup;
    rdata[B_RST] = reneg;
  end
endmodule

// File: rtl/lmr_pick.sv
module lmr_pick #(
  parameter int W  = 4,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  cand,
  output logic          hit,
  output logic [IW-1:0] idx
);
  // later (higher) bits overwrite earlier ones: highest set bit wins
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (cand[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/lmr_fsm.sv
module lmr_fsm
  import lmr_pkg::*;
#(
  parameter int AW = ABIL_W,
  parameter int IW = $clog2(AW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_link_ok,
  input  logic          reneg,
  input  logic          an_en,
  input  logic          spd,
  input  logic          dup,
  input  logic [AW-1:0] local_abil,
  input  logic          lp_valid,
  input  logic [AW-1:0] lp_abil,
  input  logic          pd_valid,
  input  logic          pd_speed100,
  output logic          link_up,
  output logic          res_fail,
  output logic          mode_spd,
  output logic          mode_dup,
  output logic          link_down_req,
  output logic          status_upd,
  output logic [AW-1:0] lp_q
);
  lmr_state_e    st;
  logic [AW-1:0] common;
  logic          hit;
  logic [IW-1:0] idx;
  logic          pd_ok;

  always_comb common = local_abil & lp_abil;

  lmr_pick #(.W(AW), .IW(IW)) u_pick (
    .cand (common),
    .hit  (hit),
    .idx  (idx)
  );

  // index bit 1 carries the speed, bit 0 the duplex
  always_comb pd_ok = local_abil[{pd_speed100, 1'b0}];

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_DOWN;
      mode_spd      <= 1'b0;
      mode_dup      <= 1'b0;
      link_down_req <= 1'b0;
      status_upd    <= 1'b0;
      lp_q          <= '0;
    end else begin
      link_down_req <= 1'b0;
      status_upd    <= 1'b0;
      if (!rx_link_ok) begin
        st <= ST_DOWN;
      end else if (reneg) begin
        st            <= ST_DOWN;
        link_down_req <= (st == ST_UP);
      end else begin
        case (st)
          ST_DOWN: begin
            if (an_en) begin
              st <= ST_NEGO;
            end else begin
              st         <= ST_UP;
              mode_spd   <= spd;
              mode_dup   <= dup;
              status_upd <= 1'b1;
            end
          end
          ST_NEGO: begin
            if (lp_valid) begin
              lp_q       <= lp_abil;
              status_upd <= 1'b1;
              if (hit) begin
                st       <= ST_UP;
                mode_spd <= idx[1];
                mode_dup <= idx[0];
              end else begin
                st <= ST_FAIL;
              end
            end else if (pd_valid) begin
              lp_q       <= '0;
              status_upd <= 1'b1;
              if (pd_ok) begin
                st       <= ST_UP;
                mode_spd <= pd_speed100;
                mode_dup <= 1'b0;
              end else begin
                st <= ST_FAIL;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    link_up  = (st == ST_UP);
    res_fail = (st == ST_FAIL);
  end
endmodule

// File: rtl/port_mode_resolver.sv
module port_mode_resolver
  import lmr_pkg::*;
#(
  parameter int CW = CTL_W,
  parameter int AW = ABIL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_wr,
  input  logic [CW-1:0] ctl_wdata,
  output logic [CW-1:0] ctl_rdata,
  input  logic [AW-1:0] local_abil,
  input  logic          lp_abil_valid,
  input  logic [AW-1:0] lp_abil,
  input  logic          pd_valid,
  input  logic          pd_speed100,
  input  logic          rx_link_ok,
  output logic          link_up,
  output logic          res_fail,
  output logic          mode_speed100,
  output logic          mode_full,
  output logic          link_down_req,
  output logic          status_upd,
  output logic [AW-1:0] lp_abil_q
);
  logic an_en, cfg_spd, cfg_dup, reneg;

  lmr_ctl_regs #(.W(CW)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr      (ctl_wr),
    .wdata   (ctl_wdata),
    .link_up (link_up),
    .cur_spd (mode_speed100),
    .an_en   (an_en),
    .spd     (cfg_spd),
    .dup     (cfg_dup),
    .reneg   (reneg),
    .rdata   (ctl_rdata)
  );

  lmr_fsm #(.AW(AW)) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .rx_link_ok    (rx_link_ok),
    .reneg         (reneg),
    .an_en         (an_en),
    .spd           (cfg_spd),
    .dup           (cfg_dup),
    .local_abil    (local_abil),
    .lp_valid      (lp_abil_valid),
    .lp_abil       (lp_abil),
    .pd_valid      (pd_valid),
    .pd_speed100   (pd_speed100),
    .link_up       (link_up),
    .res_fail      (res_fail),
    .mode_spd      (mode_speed100),
    .mode_dup      (mode_full),
    .link_down_req (link_down_req),
    .status_upd    (status_upd),
    .lp_q          (lp_abil_q)
  );
endmodule

// File: rtl/lmr_checker.sv
module lmr_checker #(
  parameter int CW = 16,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          ctl_wr,
  input logic [CW-1:0] ctl_wdata,
  input logic [CW-1:0] ctl_rdata,
  input logic [AW-1:0] local_abil,
  input logic          lp_abil_valid,
  input logic [AW-1:0] lp_abil,
  input logic          pd_valid,
  input logic          pd_speed100,
  input logic          rx_link_ok,
  input logic          link_up,
  input logic          res_fail,
  input logic          mode_speed100,
  input logic          mode_full,
  input logic          link_down_req,
  input logic          status_upd,
  input logic [AW-1:0] lp_abil_q
);
  p_restart_selfclear_r6: assert property (@(posedge clk) disable iff (rst)
    (ctl_rdata[9] && !ctl_wr) |=> !ctl_rdata[9]);

  p_drop_only_from_up_r7: assert property (@(posedge clk) disable iff (rst)
    link_down_req |-> (!link_up && $past(link_up)));

  p_mode_held_r8: assert property (@(posedge clk) disable iff (rst)
    (link_up && $past(link_up)) |-> ($stable(mode_speed100) && $stable(mode_full)));

  p_up_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(link_up) |-> status_upd);

  p_fail_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(res_fail) |-> status_upd);

  p_strobe_single_r9: assert property (@(posedge clk) disable iff (rst)
    status_upd |=> !status_upd);

  p_link_loss_r10: assert property (@(posedge clk) disable iff (rst)
    !rx_link_ok |=> (!link_up && !res_fail));
endmodule

bind port_mode_resolver lmr_checker #(.CW(CW), .AW(AW)) u_chk (.*);

// File: tb/port_mode_resolver_test.sv
`timescale 1ns/1ps
module port_mode_resolver_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_wr = 1'b0;
  logic [15:0] ctl_wdata = '0;
  logic [15:0] ctl_rdata;
  logic [3:0]  local_abil = 4'hF;
  logic        lp_abil_valid = 1'b0;
  logic [3:0]  lp_abil = '0;
  logic        pd_valid = 1'b0;
  logic        pd_speed100 = 1'b0;
  logic        rx_link_ok = 1'b0;
  logic        link_up, res_fail, mode_speed100, mode_full;
  logic        link_down_req, status_upd;
  logic [3:0]  lp_abil_q;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  port_mode_resolver uut (.*);

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    ctl_wr = 1'b1;
    ctl_wdata = d;
    tick();
    ctl_wr = 1'b0;
  endtask

  task automatic present(input bit use_pd, input logic [3:0] lp, input bit pspd);
    lp_abil_valid = !use_pd;
    lp_abil = lp;
    pd_valid = use_pd;
    pd_speed100 = pspd;
    tick();
    lp_abil_valid = 1'b0;
    pd_valid = 1'b0;
  endtask

  task automatic cycle_link();
    rx_link_ok = 1'b0;
    tick();
    rx_link_ok = 1'b1;
    tick();
  endtask

  // expected {hit, speed100, full}: scan from the top priority down
  function automatic logic [2:0] exp_neg(input logic [3:0] loc, input logic [3:0] lp);
    for (int i = 3; i >= 0; i--)
      if (loc[i] && lp[i]) return {1'b1, i[1], i[0]};
    return 3'b000;
  endfunction

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    chk("R1", "rdata", ctl_rdata, 16'h3100);
    chk("R1", "link_up", link_up, 0);
    chk("R1", "res_fail", res_fail, 0);
    chk("R1", "status_upd", status_upd, 0);
    chk("R1", "lp_q", lp_abil_q, 0);

    // R10 partner word ignored while the link is absent
    present(0, 4'hF, 0);
    chk("R10", "link_up no link", link_up, 0);
    chk("R10", "status no link", status_upd, 0);

    // R2 negotiated 100 half
    cycle_link();
    chk("R2", "nego pending", link_up, 0);
    present(0, 4'b0110, 0);
    chk("R2", "link_up", link_up, 1);
    chk("R2", "speed", mode_speed100, 1);
    chk("R2", "full", mode_full, 0);
    chk("R9", "status", status_upd, 1);
    chk("R9", "lp_q", lp_abil_q, 4'b0110);
    tick();
    chk("R9", "status single", status_upd, 0);

    // R8 deferred duplex and enable change at same speed
    wr(16'h2100);
    local_abil = 4'b0001;
    tick();
    tick();
    chk("R8", "link kept", link_up, 1);
    chk("R8", "no drop", link_down_req, 0);
    chk("R8", "full kept", mode_full, 0);
    local_abil = 4'hF;

    // R7 forced speed change while up
    wr(16'h0100);
    chk("R7", "pending", ctl_rdata[9], 1);
    chk("R7", "still up", link_up, 1);
    tick();
    chk("R7", "drop req", link_down_req, 1);
    chk("R7", "down", link_up, 0);
    tick();
    // R5 forced mode
    chk("R5", "up", link_up, 1);
    chk("R5", "speed", mode_speed100, 0);
    chk("R5", "full", mode_full, 1);
    chk("R5", "status", status_upd, 1);

    // R8 duplex change waits for a link cycle
    wr(16'h0000);
    tick();
    chk("R8", "full deferred", mode_full, 1);
    chk("R8", "up", link_up, 1);
    rx_link_ok = 1'b0;
    tick();
    chk("R10", "down on loss", link_up, 0);
    rx_link_ok = 1'b1;
    tick();
    chk("R8", "up after cycle", link_up, 1);
    chk("R8", "half applied", mode_full, 0);

    // R6 restart
    wr(16'h1200);
    chk("R6", "bit9 set", ctl_rdata[9], 1);
    tick();
    chk("R6", "bit9 clear", ctl_rdata[9], 0);
    chk("R6", "drop req", link_down_req, 1);
    chk("R6", "down", link_up, 0);
    tick();
    chk("R6", "nego", link_up, 0);

    // R3 no common ability
    local_abil = 4'b0011;
    present(0, 4'b1100, 0);
    chk("R3", "fail", res_fail, 1);
    chk("R3", "down", link_up, 0);
    chk("R3", "status", status_upd, 1);
    chk("R9", "lp_q", lp_abil_q, 4'b1100);
    tick();
    chk("R3", "fail held", res_fail, 1);
    wr(16'h1200);
    tick();
    chk("R3", "fail cleared", res_fail, 0);
    chk("R6", "no drop from fail", link_down_req, 0);
    tick();

    // R4 parallel detect
    local_abil = 4'b0101;
    present(1, 4'hF, 1);
    chk("R4", "up", link_up, 1);
    chk("R4", "speed", mode_speed100, 1);
    chk("R4", "half", mode_full, 0);
    chk("R4", "lp_q zero", lp_abil_q, 0);
    cycle_link();
    local_abil = 4'b1010;
    present(1, 4'h0, 0);
    chk("R4", "fail no 10 half", res_fail, 1);

    // random mix
    void'($urandom(32'd4242));
    for (int n = 0; n < 300; n++) begin
      logic [3:0] loc, lp;
      bit use_pd, ps, ok;
      logic [2:0] e;
      loc = 4'($urandom());
      lp = 4'($urandom());
      use_pd = ($urandom() % 4) == 0;
      ps = 1'($urandom());
      local_abil = loc;
      cycle_link();
      present(use_pd, lp, ps);
      if (use_pd) begin
        ok = ps ? loc[2] : loc[0];
        e = {ok, ps, 1'b0};
      end else begin
        e = exp_neg(loc, lp);
      end
      chk("R2", "rnd link_up", link_up, e[2]);
      chk("R3", "rnd fail", res_fail, !e[2]);
      chk("R9", "rnd status", status_upd, 1);
      chk("R9", "rnd lp_q", lp_abil_q, use_pd ? 0 : lp);
      if (e[2]) begin
        chk(use_pd ? "R4" : "R2", "rnd speed", mode_speed100, e[1]);
        chk(use_pd ? "R4" : "R2", "rnd full", mode_full, e[0]);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule